// File: doc/BRIEF.md
# Serial Command Receiver and Character Memory Writer

This block takes 16-bit command words from a three-wire serial link (active-low select, shift clock, data) and turns the character-memory commands into write strobes for a 28-column by 12-row character store and a 12-entry line store. All serial inputs are synchronised into the system clock, and shift-clock rising edges are found in that domain. A level on a direction input picks whether each word arrives least-significant bit first or most-significant bit first.

Both kinds of memory write take two commands. The first latches 12 bits. The second adds 12 bits and commits the 24-bit word. Character commits step the write address through the grid in row-major order, and line commits leave it where it is. A fill flag makes one character commit write the same word to every cell from the current address to the end of the grid, one cell per clock. Writes are held off while an external blocking input (the horizontal sync pulse) is high. Commands with codes 5 to 15 are not decoded here: they go out as a one-cycle strobe carrying the raw word.

Top module: `osd_cmd_rx`

## Requirements
- R1: A word is 16 shift-clock rising edges with select low. With `msb_first_i` low the first bit received is bit 0; with it high the first bit is bit 15. Bits 15:12 hold the command code.
- R2: If select rises before the 16th bit, the partial word is dropped and the next transfer starts from an empty bit count.
- R3: Code 0 loads the write row from bits 11:8, the fill flag from bit 7 and the write column from bits 4:0. Bits 6:5 are ignored.
- R4: Code 1 latches bits 11:0 and writes nothing.
- R5: Code 2 writes {latched code-1 field in 23:12, its own bits 11:0 in 11:0} at the write address. It then advances the column. Column 27 wraps to column 0 of the next row, and row 11 column 27 wraps to row 0 column 0.
- R6: Code 3 latches bits 11:0. Code 4 writes {code-3 field in 23:12, its own bits 11:0} to the line store at the write row and leaves row and column unchanged.
- R7: With the fill flag set, a code 2 writes the same word to every cell from the current address through row 11 column 27, one cell per unblocked clock. `busy_o` is high throughout, and the address ends at row 0 column 0.
- R8: No write strobe is raised while `wr_block_i` is high. A pending write is performed once the input falls.
- R9: Codes 5 to 15 raise `cmd_valid_o` for one cycle with the word on `cmd_word_o`. Codes 0 to 4 never raise it.
- R10: A word that completes while `busy_o` is high is discarded.
- R11: After reset the write address is row 0 column 0, both latches are zero, `busy_o` is low and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial shift clock, sampled on its rising edge |
| sdata_i | input | 1 | Serial data |
| msb_first_i | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| wr_block_i | input | 1 | High while memory writes must be held off |
| char_we_o | output | 1 | Character store write strobe |
| char_wdata_o | output | 24 | Character word to write |
| line_we_o | output | 1 | Line store write strobe |
| line_wdata_o | output | 24 | Line word to write |
| wr_row_o | output | 4 | Current write row (character and line store) |
| wr_col_o | output | 5 | Current write column |
| busy_o | output | 1 | A write or fill is pending |
| cmd_valid_o | output | 1 | One-cycle strobe for a forwarded command |
| cmd_word_o | output | 16 | Raw forwarded command word |

## Verification
The bench sends the same kind of word in both bit orders. A receiver with the wrong order or shift direction would load a scrambled row and column. It aborts a transfer after 7 bits and then sends a full word. A receiver that kept the leftover count would assemble a misaligned word and go to the wrong address. Character commits are placed at column 27 and at the last cell, where a bad wrap would step into column 28 or row 12, and a fill started mid-grid must produce exactly 36 sequential writes, ending at the origin. Under the blocking input the bench checks that the commit waits, and that a word arriving meanwhile changes nothing. A design that queued or applied that word would leave the address at the dropped word's row and column.

// File: rtl/osd_cmd_pkg.sv
`timescale 1ns/1ps
package osd_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int HALF_W = 12;
  localparam int DATA_W = 2 * HALF_W;

  // field positions inside a code-0 word
  localparam int ROW_LSB  = 8;
  localparam int FILL_BIT = 7;
  localparam int COL_LSB  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADDR = 4'd0,
    OP_CHR1 = 4'd1,
    OP_CHR2 = 4'd2,
    OP_LIN1 = 4'd3,
    OP_LIN2 = 4'd4
  } op_e;
endpackage

// File: rtl/osd_sync.sv
`timescale 1ns/1ps
module osd_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/osd_serial_rx.sv
`timescale 1ns/1ps
module osd_serial_rx
  import osd_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              msb_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sclk_rise;

  assign sclk_rise = sclk_i & ~sclk_q;

  always_comb begin
    if (msb_i) sr_d = {sr_q[WORD_W-2:0], sdat_i};
    else       sr_d = {sdat_i, sr_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sclk_q     <= sclk_i;
      word_vld_o <= 1'b0;
      if (cs_n_i) begin
        cnt_q <= '0;  // partial word dropped
      end else if (sclk_rise) begin
        sr_q <= sr_d;
        if (cnt_q == CNT_LAST) begin
          cnt_q      <= '0;
          word_vld_o <= 1'b1;
          word_o     <= sr_d;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/osd_vram_wr.sv
`timescale 1ns/1ps
module osd_vram_wr
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 28,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              blk_i,
  output logic              char_we_o,
  output logic [DATA_W-1:0] char_wdata_o,
  output logic              line_we_o,
  output logic [DATA_W-1:0] line_wdata_o,
  output logic [RW-1:0]     row_o,
  output logic [CW-1:0]     col_o,
  output logic              busy_o,
  output logic              cmd_vld_o,
  output logic [WORD_W-1:0] cmd_word_o
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [RW-1:0]     row_q, row_nx;
  logic [CW-1:0]     col_q, col_nx;
  logic              fill_q;
  logic [HALF_W-1:0] chr_lat_q, lin_lat_q;
  logic              chr_pend_q, lin_pend_q;
  logic [DATA_W-1:0] chr_dat_q, lin_dat_q;
  logic              accept, last_cell;
  logic [OP_W-1:0]   op;

  assign op        = word_i[WORD_W-1 -: OP_W];
  assign accept    = word_vld_i & ~busy_o;
  assign last_cell = (row_q == ROW_LAST) && (col_q == COL_LAST);

  always_comb begin
    if (col_q == COL_LAST) begin
      col_nx = '0;
      row_nx = (row_q == ROW_LAST) ? '0 : row_q + RW'(1);
    end else begin
      col_nx = col_q + CW'(1);
      row_nx = row_q;
    end
  end

  assign busy_o       = chr_pend_q | lin_pend_q;
  assign char_we_o    = chr_pend_q & ~blk_i;
  assign line_we_o    = lin_pend_q & ~blk_i;
  assign char_wdata_o = chr_dat_q;
  assign line_wdata_o = lin_dat_q;
  assign row_o        = row_q;
  assign col_o        = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q      <= '0;
      col_q      <= '0;
      fill_q     <= 1'b0;
      chr_lat_q  <= '0;
      lin_lat_q  <= '0;
      chr_pend_q <= 1'b0;
      lin_pend_q <= 1'b0;
      chr_dat_q  <= '0;
      lin_dat_q  <= '0;
      cmd_vld_o  <= 1'b0;
      cmd_word_o <= '0;
    end else begin
      cmd_vld_o <= 1'b0;

      if (char_we_o) begin
        row_q <= row_nx;
        col_q <= col_nx;
        if (!fill_q || last_cell) chr_pend_q <= 1'b0;
      end
      if (line_we_o) lin_pend_q <= 1'b0;

      if (accept) begin
        unique case (op)
          OP_ADDR: begin
            row_q  <= word_i[ROW_LSB +: RW];
            col_q  <= word_i[COL_LSB +: CW];
            fill_q <= word_i[FILL_BIT];
          end
          OP_CHR1: chr_lat_q <= word_i[HALF_W-1:0];
          OP_CHR2: begin
            chr_dat_q  <= {chr_lat_q, word_i[HALF_W-1:0]};
            chr_pend_q <= 1'b1;
          end
          OP_LIN1: lin_lat_q <= word_i[HALF_W-1:0];
          OP_LIN2: begin
            lin_dat_q  <= {lin_lat_q, word_i[HALF_W-1:0]};
            lin_pend_q <= 1'b1;
          end
          default: begin
            cmd_vld_o  <= 1'b1;
            cmd_word_o <= word_i;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/osd_cmd_rx.sv
`timescale 1ns/1ps
module osd_cmd_rx
  import osd_cmd_pkg::*;
#(
  parameter int ROWS        = 12,
  parameter int COLS        = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              msb_first_i,
  input  logic              wr_block_i,
  output logic              char_we_o,
  output logic [DATA_W-1:0] char_wdata_o,
  output logic              line_we_o,
  output logic [DATA_W-1:0] line_wdata_o,
  output logic [$clog2(ROWS)-1:0] wr_row_o,
  output logic [$clog2(COLS)-1:0] wr_col_o,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o
);
  logic [3:0]        pins_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  // pins_s: {msb, data, sclk, cs_n}; cs_n resets to idle high
  osd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({msb_first_i, sdata_i, sclk_i, cs_ni}),
    .q_o    (pins_s)
  );

  osd_serial_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (pins_s[0]),
    .sclk_i     (pins_s[1]),
    .sdat_i     (pins_s[2]),
    .msb_i      (pins_s[3]),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  osd_vram_wr #(.ROWS(ROWS), .COLS(COLS)) i_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (word),
    .blk_i        (wr_block_i),
    .char_we_o    (char_we_o),
    .char_wdata_o (char_wdata_o),
    .line_we_o    (line_we_o),
    .line_wdata_o (line_wdata_o),
    .row_o        (wr_row_o),
    .col_o        (wr_col_o),
    .busy_o       (busy_o),
    .cmd_vld_o    (cmd_valid_o),
    .cmd_word_o   (cmd_word_o)
  );
endmodule

// File: rtl/osd_cmd_rx_chk.sv
`timescale 1ns/1ps
module osd_cmd_rx_chk #(
  parameter int ROWS = 12,
  parameter int COLS = 28,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_block_i,
  input logic          char_we_o,
  input logic          line_we_o,
  input logic [RW-1:0] wr_row_o,
  input logic [CW-1:0] wr_col_o,
  input logic          busy_o,
  input logic          cmd_valid_o,
  input logic [15:0]   cmd_word_o
);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  // R8: nothing written while blocked
  a_r8_no_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_i |-> !char_we_o && !line_we_o);

  // R8: a pending write proceeds as soon as unblocked
  a_r8_pending_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !wr_block_i |-> char_we_o || line_we_o);

  // R5: column steps by one (wrapping) after each character write
  a_r5_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_we_o |=> wr_col_o == (($past(wr_col_o) == COL_LAST) ? '0 : $past(wr_col_o) + CW'(1)));

  // R6: a line write keeps the address
  a_r6_line_keeps_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_we_o |=> $stable(wr_row_o) && $stable(wr_col_o));

  // R9: only codes above 4 are forwarded
  a_r9_fwd_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_word_o[15:12] > 4'd4);

  // R9: forward strobe never coincides with a memory write
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({char_we_o, line_we_o, cmd_valid_o}));
endmodule

bind osd_cmd_rx osd_cmd_rx_chk #(.ROWS(ROWS), .COLS(COLS)) i_osd_cmd_rx_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_block_i  (wr_block_i),
  .char_we_o   (char_we_o),
  .line_we_o   (line_we_o),
  .wr_row_o    (wr_row_o),
  .wr_col_o    (wr_col_o),
  .busy_o      (busy_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_word_o  (cmd_word_o)
);

// File: tb/test_osd_cmd_rx.sv
`timescale 1ns/1ps
module test_osd_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdat = 1'b0, msb = 1'b0, blk = 1'b0;
  logic        char_we, line_we, busy, cmd_valid;
  logic [23:0] char_wdata, line_wdata;
  logic [3:0]  wr_row;
  logic [4:0]  wr_col;
  logic [15:0] cmd_word;

  int nchk = 0, nerr = 0;
  int nchar = 0, nline = 0, ncmd = 0, nbusy = 0;
  logic [23:0] lg_d [0:511];
  logic [3:0]  lg_r [0:511];
  logic [4:0]  lg_c [0:511];
  logic [23:0] last_line_d = '0;
  logic [3:0]  last_line_r = '0;
  logic [15:0] last_cmd = '0;
  bit done = 0;

  always #5 clk = ~clk;

  osd_cmd_rx i_osd_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdata_i(sdat),
    .msb_first_i(msb), .wr_block_i(blk),
    .char_we_o(char_we), .char_wdata_o(char_wdata),
    .line_we_o(line_we), .line_wdata_o(line_wdata),
    .wr_row_o(wr_row), .wr_col_o(wr_col), .busy_o(busy),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word)
  );

  always @(negedge clk) if (rst_n) begin
    if (char_we) begin
      if (nchar < 512) begin
        lg_d[nchar] = char_wdata; lg_r[nchar] = wr_row; lg_c[nchar] = wr_col;
      end
      nchar++;
    end
    if (line_we) begin nline++; last_line_d = line_wdata; last_line_r = wr_row; end
    if (cmd_valid) begin ncmd++; last_cmd = cmd_word; end
    if (busy) nbusy++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] w, input logic m, input int n);
    msb = m;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = m ? w[15-i] : w[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    send_bits(w, 1'b1, 16);
  endtask

  function automatic logic [15:0] addr_w(input int r, input int c, input bit f);
    return {4'h0, 4'(r), f, 2'b00, 5'(c)};
  endfunction

  task automatic t_reset();
    chk("R11 busy after reset", 32'(busy), 0);
    chk("R11 row after reset", 32'(wr_row), 0);
    chk("R11 col after reset", 32'(wr_col), 0);
    chk("R11 no strobes", 32'(nchar + nline + ncmd), 0);
  endtask

  task automatic t_order();
    send_bits(addr_w(3, 5, 0), 1'b1, 16);
    chk("R1 R3 msb-first row", 32'(wr_row), 3);
    chk("R1 R3 msb-first col", 32'(wr_col), 5);
    send_bits(addr_w(7, 20, 0) | 16'h0060, 1'b0, 16);  // bits 6:5 ignored (R3)
    chk("R1 lsb-first row", 32'(wr_row), 7);
    chk("R1 R3 lsb-first col", 32'(wr_col), 20);
  endtask

  task automatic t_char();
    int n0;
    send(addr_w(2, 26, 0));
    n0 = nchar;
    send(16'h1ABC);
    chk("R4 stage 1 writes nothing", 32'(nchar - n0), 0);
    send(16'h25A3);
    chk("R5 one write", 32'(nchar - n0), 1);
    chk("R5 data", 32'(lg_d[n0]), 32'hABC5A3);
    chk("R5 write row", 32'(lg_r[n0]), 2);
    chk("R5 write col", 32'(lg_c[n0]), 26);
    chk("R5 incr col", 32'(wr_col), 27);
    send(16'h2111);
    chk("R5 data at col 27", 32'(lg_d[n0+1]), 32'hABC111);
    chk("R5 wrap row", 32'(wr_row), 3);
    chk("R5 wrap col", 32'(wr_col), 0);
    send(addr_w(11, 27, 0));
    send(16'h2222);
    chk("R5 last cell row", 32'(lg_r[n0+2]), 11);
    chk("R5 end wrap row", 32'(wr_row), 0);
    chk("R5 end wrap col", 32'(wr_col), 0);
  endtask

  task automatic t_line();
    int n0, c0;
    send(addr_w(4, 9, 0));
    n0 = nline; c0 = nchar;
    send(16'h3123);
    chk("R6 stage 1 writes nothing", 32'(nline - n0), 0);
    send(16'h4456);
    chk("R6 one line write", 32'(nline - n0), 1);
    chk("R6 line data", 32'(last_line_d), 32'h123456);
    chk("R6 line row", 32'(last_line_r), 4);
    chk("R6 row kept", 32'(wr_row), 4);
    chk("R6 col kept", 32'(wr_col), 9);
    chk("R6 no char write", 32'(nchar - c0), 0);
  endtask

  task automatic t_abort();
    send_bits(16'hFFFF, 1'b1, 7);
    send(addr_w(1, 1, 0));
    chk("R2 row after abort", 32'(wr_row), 1);
    chk("R2 col after abort", 32'(wr_col), 1);
    send_bits(16'h0000, 1'b0, 5);
    send_bits(addr_w(6, 13, 0), 1'b0, 16);
    chk("R2 lsb abort row", 32'(wr_row), 6);
    chk("R2 lsb abort col", 32'(wr_col), 13);
  endtask

  task automatic t_forward();
    int n0;
    n0 = ncmd;
    send(16'h5123);
    chk("R9 forward count", 32'(ncmd - n0), 1);
    chk("R9 forward word", 32'(last_cmd), 32'h5123);
    send(16'hF00D);
    chk("R9 code 15 forwarded", 32'(last_cmd), 32'hF00D);
    send(16'h1000);
    send(16'h3000);
    chk("R9 codes 1 and 3 not forwarded", 32'(ncmd - n0), 2);
  endtask

  task automatic t_block();
    int n0;
    blk = 1'b1;
    send(addr_w(5, 0, 0));
    send(16'h1777);
    n0 = nchar;
    send(16'h2888);
    chk("R8 held while blocked", 32'(nchar - n0), 0);
    chk("R8 busy while held", 32'(busy), 1);
    send(addr_w(9, 9, 0));  // dropped while busy
    @(negedge clk); blk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 write after release", 32'(nchar - n0), 1);
    chk("R8 data after release", 32'(lg_d[n0]), 32'h777888);
    chk("R8 R10 written at held address", 32'({lg_r[n0], lg_c[n0]}), 32'({4'd5, 5'd0}));
    chk("R10 row not from dropped word", 32'(wr_row), 5);
    chk("R10 col not from dropped word", 32'(wr_col), 1);
    chk("R8 busy cleared", 32'(busy), 0);
  endtask

  task automatic t_fill();
    int n0, b0, bad, r, c;
    send(addr_w(10, 20, 1));
    send(16'h10F0);
    n0 = nchar; b0 = nbusy;
    send(16'h2321);
    repeat (60) @(negedge clk);
    chk("R7 fill count", 32'(nchar - n0), 36);
    chk("R7 busy cycles", 32'(nbusy - b0), 36);
    bad = 0; r = 10; c = 20;
    for (int i = 0; i < 36; i++) begin
      if (lg_d[n0+i] !== 24'h0F0321 || lg_r[n0+i] !== 4'(r) || lg_c[n0+i] !== 5'(c)) bad++;
      c++;
      if (c == 28) begin c = 0; r++; end
    end
    chk("R7 fill cells sequential and equal", 32'(bad), 0);
    chk("R7 end row", 32'(wr_row), 0);
    chk("R7 end col", 32'(wr_col), 0);
    chk("R7 idle after fill", 32'(busy), 0);
    send(addr_w(0, 0, 0));
    n0 = nchar;
    send(16'h2001);
    chk("R7 fill off single write", 32'(nchar - n0), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_char();
    t_line();
    t_abort();
    t_forward();
    t_block();
    t_fill();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule